// File: doc/BRIEF.md
# Paired Load Operand Forwarding Unit

This unit sits between the return of a memory load and the execute stage of two instruction pipes that issue as a pair. The older instruction of the pair runs in the X pipe and the younger one runs in the Y pipe. When the X instruction is a register-load move, Y may read the register that X loads, or the same memory operand. In that case the returning load data goes straight into Y's operand, in the same cycle it reaches X. Y does not wait for X's writeback. A read-after-write hazard inside one issued pair therefore costs no stall beyond the load latency itself.

Each Y source compares its physical tag against X's physical destination tag. A source may also be marked as the pair's shared memory operand. A matching source takes the load data. Every other source passes the normal register-read value through unchanged. Y is released (`y_go`) as soon as all of its sources are ready. A Y instruction with no dependency leaves at once, even while X's load is still outstanding. Forwarding of ALU results is not part of this unit.

The controller is a four-state machine. `ST_IDLE` waits for a pair. `ST_PASS` is the single release cycle of a pair whose X is not a load. `ST_LOAD_BOTH` means the load is outstanding and Y has not left yet. `ST_LOAD_X` means Y has left and only X waits for the load. The transitions are:
- IDLE→PASS on an issue with no load.
- IDLE→LOAD_BOTH on an issue with a load.
- PASS→IDLE always.
- LOAD_BOTH→IDLE when the load returns.
- LOAD_BOTH→LOAD_X when Y leaves first.
- LOAD_X→IDLE when the load returns.

Top module: `pair_load_fwd`

## Requirements
- R1: While reset is held and after its release, `y_opnd_rdy`, `y_go` and `x_ld_rdy` are all 0 until a pair is issued.
- R2: A pair issued with `x_is_load`=0 is captured on the clock edge. In the following cycle `y_go`=1, both `y_opnd_rdy` bits are 1, and each `y_opnd[i]` equals `y_rf_data[i]`. The cycle after that, the unit is idle.
- R3: In a load pair, a Y source whose tag equals `x_dst_tag` stays not ready while `ld_valid`=0. It becomes ready, with `y_opnd[i]` = `ld_data`, in the same cycle `ld_valid`=1, however long the load is delayed.
- R4: In a load pair, `x_ld_rdy`=1 and `x_ld_data`=`ld_data` exactly in the cycle `ld_valid`=1 while the load is outstanding. This is the same cycle in which a dependent Y operand becomes ready.
- R5: A Y source that does not match is ready in every cycle Y is pending, and its `y_opnd[i]` equals the live `y_rf_data[i]`.
- R6: A source with `y_src_mem[i]`=1 is the pair's shared memory operand. It receives the load data under R3 even when its tag differs from `x_dst_tag`.
- R7: In a load pair where Y has no matching source, `y_go`=1 in the first cycle after issue, and X keeps waiting for `ld_valid`.
- R8: `y_go` is 1 for exactly one cycle per pair, and only when both `y_opnd_rdy` bits are 1.
- R9: `pair_issue` is ignored while the unit is not idle. `ld_valid` is ignored while no load is outstanding.
- R10: The unit is idle in the cycle after the load returns, and it accepts a new pair in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pair_issue | input | 1 | A new X/Y pair is presented |
| x_is_load | input | 1 | X instruction is a register-load move |
| x_dst_tag | input | TAG_W | Physical destination tag of X |
| y_src_tag | input | NSRC*TAG_W | Physical source tags of Y |
| y_src_mem | input | NSRC | Y source is the pair's shared memory operand |
| y_rf_data | input | NSRC*DW | Register-read values for Y's sources |
| ld_valid | input | 1 | Load data returns this cycle |
| ld_data | input | DW | Returning load data |
| x_ld_rdy | output | 1 | X's load data is valid this cycle |
| x_ld_data | output | DW | X's load data |
| y_opnd | output | NSRC*DW | Y operand values |
| y_opnd_rdy | output | NSRC | Y operand ready flags |
| y_go | output | 1 | Y released to execute this cycle |

## Verification
Two functions can fall in the same cycle: the load return that completes X, and the forwarding that releases a dependent Y. The bench provokes this by holding the load back for zero to several cycles after issue, with the dependency on one source, on both sources, or through the shared-memory flag. It then checks that `x_ld_rdy`, the forwarded operand, its ready flag and `y_go` all rise in the one cycle `ld_valid` is high. A second collision is a new issue that arrives in the very cycle the load retires. The bench judges it by whether the captured tags of the old pair survive.

// File: rtl/lfw_pkg.sv
package lfw_pkg;
    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,
        ST_PASS      = 2'd1,
        ST_LOAD_BOTH = 2'd2,
        ST_LOAD_X    = 2'd3
    } lfw_state_e;
endpackage

// File: rtl/lfw_src_sel.sv
module lfw_src_sel #(
    parameter int TAG_W = 5,
    parameter int DW    = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             x_load,
    input  logic [TAG_W-1:0] x_dst,
    input  logic [TAG_W-1:0] src_tag,
    input  logic             src_mem,
    input  logic [DW-1:0]    rf_data,
    input  logic             ld_valid,
    input  logic [DW-1:0]    ld_data,
    input  logic             y_pending,
    output logic             fwd,
    output logic [DW-1:0]    opnd,
    output logic             opnd_rdy
);
    always_comb begin
        fwd      = x_load && (src_mem || (src_tag == x_dst));
        opnd     = fwd ? ld_data : rf_data;
        opnd_rdy = y_pending && (!fwd || ld_valid);
    end

    AST_FWD_WAITS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (opnd_rdy && fwd) |-> (ld_valid && opnd == ld_data)); // R3
    AST_PLAIN_FROM_RF: assert property (@(posedge clk) disable iff (!rst_n)
        (opnd_rdy && !fwd) |-> (opnd == rf_data)); // R5
endmodule

// File: rtl/lfw_ctrl.sv
module lfw_ctrl
    import lfw_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pair_issue,
    input  logic x_is_load,
    input  logic ld_valid,
    input  logic any_fwd,
    output logic capture,
    output logic unit_idle,
    output logic y_pending,
    output logic x_waiting,
    output logic y_go
);
    lfw_state_e state, state_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:      if (pair_issue) state_nx = x_is_load ? ST_LOAD_BOTH : ST_PASS;
            ST_PASS:      state_nx = ST_IDLE;
            ST_LOAD_BOTH: begin
                if (ld_valid)      state_nx = ST_IDLE;
                else if (!any_fwd) state_nx = ST_LOAD_X;
            end
            ST_LOAD_X:    if (ld_valid) state_nx = ST_IDLE;
            default:      state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        capture   = 1'b0;
        unit_idle = 1'b0;
        y_pending = 1'b0;
        x_waiting = 1'b0;
        y_go      = 1'b0;
        unique case (state)
            ST_IDLE: begin
                unit_idle = 1'b1;
                capture   = pair_issue;
            end
            ST_PASS: begin
                y_pending = 1'b1;
                y_go      = 1'b1;
            end
            ST_LOAD_BOTH: begin
                y_pending = 1'b1;
                x_waiting = 1'b1;
                y_go      = ld_valid || !any_fwd;
            end
            ST_LOAD_X: x_waiting = 1'b1;
            default: ;
        endcase
    end

    AST_PASS_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PASS) |-> y_go); // R2
    AST_GO_ONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        y_go |=> !y_go); // R8
    AST_RETIRE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (x_waiting && ld_valid) |=> unit_idle); // R10
endmodule

// File: rtl/pair_load_fwd.sv
module pair_load_fwd #(
    parameter int TAG_W = 5,
    parameter int DW    = 32,
    parameter int NSRC  = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       pair_issue,
    input  logic                       x_is_load,
    input  logic [TAG_W-1:0]           x_dst_tag,
    input  logic [NSRC-1:0][TAG_W-1:0] y_src_tag,
    input  logic [NSRC-1:0]            y_src_mem,
    input  logic [NSRC-1:0][DW-1:0]    y_rf_data,
    input  logic                       ld_valid,
    input  logic [DW-1:0]              ld_data,
    output logic                       x_ld_rdy,
    output logic [DW-1:0]              x_ld_data,
    output logic [NSRC-1:0][DW-1:0]    y_opnd,
    output logic [NSRC-1:0]            y_opnd_rdy,
    output logic                       y_go
);
    logic                       capture, unit_idle, y_pending, x_waiting;
    logic                       x_load_q;
    logic [TAG_W-1:0]           x_dst_q;
    logic [NSRC-1:0][TAG_W-1:0] y_tag_q;
    logic [NSRC-1:0]            y_mem_q;
    logic [NSRC-1:0]            fwd_vec;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            x_load_q <= 1'b0;
            x_dst_q  <= '0;
            y_tag_q  <= '0;
            y_mem_q  <= '0;
        end else if (capture) begin
            x_load_q <= x_is_load;
            x_dst_q  <= x_dst_tag;
            y_tag_q  <= y_src_tag;
            y_mem_q  <= y_src_mem;
        end
    end

    lfw_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .pair_issue(pair_issue),
        .x_is_load (x_is_load),
        .ld_valid  (ld_valid),
        .any_fwd   (|fwd_vec),
        .capture   (capture),
        .unit_idle (unit_idle),
        .y_pending (y_pending),
        .x_waiting (x_waiting),
        .y_go      (y_go)
    );

    for (genvar i = 0; i < NSRC; i++) begin : g_src
        lfw_src_sel #(.TAG_W(TAG_W), .DW(DW)) u_sel (
            .clk      (clk),
            .rst_n    (rst_n),
            .x_load   (x_load_q),
            .x_dst    (x_dst_q),
            .src_tag  (y_tag_q[i]),
            .src_mem  (y_mem_q[i]),
            .rf_data  (y_rf_data[i]),
            .ld_valid (ld_valid),
            .ld_data  (ld_data),
            .y_pending(y_pending),
            .fwd      (fwd_vec[i]),
            .opnd     (y_opnd[i]),
            .opnd_rdy (y_opnd_rdy[i])
        );
    end

    assign x_ld_rdy  = x_waiting && ld_valid;
    assign x_ld_data = ld_data;

    AST_XRDY_NEEDS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        x_ld_rdy |-> ld_valid); // R4
    AST_GO_ALL_READY: assert property (@(posedge clk) disable iff (!rst_n)
        y_go |-> (&y_opnd_rdy)); // R8
    AST_BUSY_ISSUE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (!unit_idle && pair_issue) |=> ($stable(x_dst_q) && $stable(y_tag_q))); // R9
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        unit_idle |-> (!x_ld_rdy && !y_go && y_opnd_rdy == '0)); // R1
endmodule

// File: tb/test_pair_load_fwd.sv
module test_pair_load_fwd;
    localparam int TAG_W = 5;
    localparam int DW    = 32;
    localparam int NSRC  = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pair_issue = 1'b0, x_is_load = 1'b0, ld_valid = 1'b0;
    logic [TAG_W-1:0] x_dst_tag = '0;
    logic [NSRC-1:0][TAG_W-1:0] y_src_tag = '0;
    logic [NSRC-1:0] y_src_mem = '0;
    logic [NSRC-1:0][DW-1:0] y_rf_data = '0;
    logic [DW-1:0] ld_data = '0;
    logic x_ld_rdy, y_go;
    logic [DW-1:0] x_ld_data;
    logic [NSRC-1:0][DW-1:0] y_opnd;
    logic [NSRC-1:0] y_opnd_rdy;

    int errors = 0, checks = 0, cycles = 0;
    string cur_req = "R1";

    // behavioural reference: 0 idle, 1 pass, 2 load+Y pending, 3 load only
    int m_mode = 0;
    bit m_xl;
    int m_dst;
    int m_tag[NSRC];
    bit m_mem[NSRC];

    always #4 clk = ~clk;

    pair_load_fwd #(.TAG_W(TAG_W), .DW(DW), .NSRC(NSRC)) i_pair_load_fwd (
        .clk(clk), .rst_n(rst_n), .pair_issue(pair_issue), .x_is_load(x_is_load),
        .x_dst_tag(x_dst_tag), .y_src_tag(y_src_tag), .y_src_mem(y_src_mem),
        .y_rf_data(y_rf_data), .ld_valid(ld_valid), .ld_data(ld_data),
        .x_ld_rdy(x_ld_rdy), .x_ld_data(x_ld_data), .y_opnd(y_opnd),
        .y_opnd_rdy(y_opnd_rdy), .y_go(y_go));

    function automatic bit exp_fwd(int i);
        return m_xl && (m_mem[i] || m_tag[i] == m_dst);
    endfunction

    function automatic bit exp_pend();
        return (m_mode == 1) || (m_mode == 2);
    endfunction

    function automatic bit exp_rdy(int i);
        return exp_pend() && (!exp_fwd(i) || ld_valid);
    endfunction

    task automatic chk(string what, longint act, longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s act=%0h exp=%0h t=%0t", cur_req, what, act, exp, $time);
        end
    endtask

    // model update on every edge
    always @(posedge clk) begin
        cycles++;
        if (!rst_n) m_mode = 0;
        else begin
            bit go_e;
            go_e = exp_pend();
            for (int i = 0; i < NSRC; i++) if (!exp_rdy(i)) go_e = 0;
            case (m_mode)
                0: if (pair_issue) begin
                       m_xl = x_is_load; m_dst = x_dst_tag;
                       for (int i = 0; i < NSRC; i++) begin
                           m_tag[i] = y_src_tag[i]; m_mem[i] = y_src_mem[i];
                       end
                       m_mode = x_is_load ? 2 : 1;
                   end
                1: m_mode = 0;
                2: if (ld_valid) m_mode = 0; else if (go_e) m_mode = 3;
                3: if (ld_valid) m_mode = 0;
                default: m_mode = 0;
            endcase
        end
    end

    // compare every cycle, away from the active edge
    always @(negedge clk) begin
        #2;
        begin
            bit go_e;
            go_e = exp_pend();
            for (int i = 0; i < NSRC; i++) if (!exp_rdy(i)) go_e = 0;
            chk("y_go(R8)", y_go, go_e);
            chk("x_ld_rdy(R4)", x_ld_rdy, (m_mode >= 2) && ld_valid);
            if (x_ld_rdy) chk("x_ld_data(R4)", x_ld_data, ld_data);
            for (int i = 0; i < NSRC; i++) begin
                chk($sformatf("y_opnd_rdy[%0d]", i), y_opnd_rdy[i], exp_rdy(i));
                if (exp_rdy(i))
                    chk($sformatf("y_opnd[%0d]", i), y_opnd[i],
                        exp_fwd(i) ? ld_data : y_rf_data[i]);
            end
        end
    end

    // live register-read path changes every cycle
    always @(negedge clk) y_rf_data <= {$urandom, $urandom};

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic issue(bit xl, int dst, int t0, int t1, bit mem1);
        pair_issue = 1; x_is_load = xl; x_dst_tag = dst;
        y_src_tag[0] = t0; y_src_tag[1] = t1; y_src_mem = {mem1, 1'b0};
        step(1);
        pair_issue = 0; x_is_load = 0;
    endtask

    task automatic load(logic [DW-1:0] d);
        ld_valid = 1; ld_data = d;
        step(1);
        ld_valid = 0; ld_data = $urandom;
    endtask

    initial begin
        step(3);
        cur_req = "R1";
        chk("reset y_go", y_go, 0);
        chk("reset x_ld_rdy", x_ld_rdy, 0);
        rst_n = 1;
        step(2);
        chk("idle y_opnd_rdy", y_opnd_rdy, 0);

        cur_req = "R2";              // X not a load
        issue(0, 3, 3, 3, 0); step(3);

        cur_req = "R3";              // src0 depends, load 3 cycles late
        issue(1, 7, 7, 2, 0); step(3); load(32'hA5A5_0001); step(2);

        cur_req = "R3";              // src1 depends, load next cycle
        issue(1, 9, 1, 9, 0); load(32'h1234_5678); step(1);

        cur_req = "R4";              // both depend, load at once with X
        issue(1, 4, 4, 4, 0); load(32'hCAFE_F00D); step(2);

        cur_req = "R7";              // independent Y leaves before load
        issue(1, 5, 6, 8, 0); step(4);
        cur_req = "R5";
        load(32'h0BAD_BEEF); step(1);

        cur_req = "R6";              // shared memory operand, tag mismatch
        issue(1, 10, 11, 12, 1); step(2); load(32'h5EED_0006); step(1);

        cur_req = "R9";              // issue while busy and stray load
        issue(1, 13, 13, 0, 0);
        issue(0, 20, 21, 22, 0);
        issue(1, 14, 14, 14, 0);
        load(32'h7777_0009); step(1);
        load(32'h8888_0009); step(2);

        cur_req = "R10";             // new pair in the retiring cycle
        issue(1, 15, 15, 1, 0); step(1);
        ld_valid = 1; ld_data = 32'h1010_1010;
        pair_issue = 1; x_is_load = 0; x_dst_tag = 2; y_src_tag = '0; y_src_mem = '0;
        step(1);
        ld_valid = 0; pair_issue = 0;
        step(1);
        issue(1, 16, 2, 16, 0); load(32'h2020_2020); step(3);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    always @(posedge clk) begin
        if (cycles > 20000) begin
            errors++; checks++;
            $display("FAIL watchdog act=%0d exp=<20000", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule